// File: doc/BRIEF.md
# Cipher DMA Job Shadow Sequencer

This block runs the data movement for a block-cipher job. Software programs a source pointer, a destination pointer and a byte count through a small word-addressed write port. These are staged values. A start command copies them into a separate set of active registers, which the running job then consumes. Software can therefore prepare the next job while the current one is still moving data. For each 16-byte block the sequencer reads the block from memory, hands it to the cipher core over a valid/ready pair, collects the core's result and writes it to the destination. The block is read before its result is written, so source and destination may be the same buffer.

A job can be split into segments. With chaining selected, the block finishes a segment, keeps busy high and waits. The next start loads fresh pointers and a fresh count and does not restart the core, so the core's chaining state carries over. A final-round flag travels with one start command only and marks the segment that ends the job. A start with a zero count raises a count error and moves no data. An error response on the memory port stops the job, asks the core to abort and sets a sticky bus-error flag.

Top module: `cdma_shadow_seq`

## Requirements
- R1: After reset `busy`, `cnt_err`, `bus_err`, `mem_req_valid` and `core_in_valid` are all low.
- R2: Register word offsets are 0 control, 1 source pointer, 2 destination pointer, 3 byte count. Bits 1 and 0 of a written pointer are dropped and read as zero, so every memory request address has its two low bits clear.
- R3: A start (control bit 0) issued while idle with a staged count of zero sets `cnt_err`, keeps `busy` low and issues no memory request. The next accepted start clears `cnt_err`.
- R4: A job of N bytes moves ceil(N/16) blocks. Block k is read at source+16k and its core result is written at destination+16k. The remaining count drops by 16 per block and saturates at zero for a short final block.
- R5: Each block's read completes before that block's write is issued, so a job whose source equals its destination gives correct results in place.
- R6: Writes to the pointer and count registers while busy do not change the running job. They take effect at the next start.
- R7: `seg_fed` pulses exactly once per segment, in the cycle the segment's last block is accepted by the core.
- R8: With chaining (control bit 2) set on the opening start and the final-round bit (control bit 3) clear, `busy` stays high after the segment's last write. A following start loads the new staged segment without a `core_job_start` pulse. `core_job_start` pulses only on a start from idle.
- R9: The final-round bit acts only on the start write that carries it. A later chained start without it leaves the job waiting again.
- R10: An error response to a read or a write ends the job, pulses `core_abort`, and sets `bus_err`. `bus_err` stays set until the next accepted start.
- R11: Stop (control bit 1) while busy drops `busy` on the next edge, pulses `core_abort`, and no further memory request follows.
- R12: `busy` rises on the edge that takes an accepted start. It falls after the final segment's last write response.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_wr_en | input | 1 | Register write strobe |
| reg_addr | input | REG_AW | Register word offset |
| reg_wdata | input | REG_DW | Register write data |
| mem_req_valid | output | 1 | Memory request valid |
| mem_req_ready | input | 1 | Memory request accepted |
| mem_req_write | output | 1 | 1 = write request, 0 = read request |
| mem_req_addr | output | ADDR_W | Byte address of the block |
| mem_req_data | output | BLK_BYTES*8 | Write data |
| mem_rsp_valid | input | 1 | Memory response valid |
| mem_rsp_data | input | BLK_BYTES*8 | Read data |
| mem_rsp_err | input | 1 | Response carries an error |
| core_in_valid | output | 1 | Block offered to the cipher core |
| core_in_ready | input | 1 | Core accepts the block |
| core_in_data | output | BLK_BYTES*8 | Block to the core |
| core_out_valid | input | 1 | Core result valid |
| core_out_ready | output | 1 | Sequencer takes the result |
| core_out_data | input | BLK_BYTES*8 | Core result |
| core_job_start | output | 1 | Pulse: fresh job, core resets chaining state |
| core_abort | output | 1 | Pulse: core must abandon its work |
| busy | output | 1 | Job in progress |
| seg_fed | output | 1 | Pulse: last block of a segment given to core |
| cnt_err | output | 1 | Zero-count start seen |
| bus_err | output | 1 | Sticky memory error flag |

## Verification
The bench builds the block with a 16-bit address width and the default 32-bit count and 16-byte block. A 1 KB memory model then covers every pointer the tests use, and byte counts that are not multiples of the block size are easy to pick. The memory model can return an error on one chosen address, which places a bus fault at a chosen block. Because the core model is a plain XOR, every destination block has a known value that depends on its source block. This lets the bench check the pointer stepping, the in-place ordering and the segment chaining.

// File: rtl/cdma_pkg.sv
package cdma_pkg;

   // register word offsets
   localparam int unsigned REG_CTRL = 0;
   localparam int unsigned REG_SRC  = 1;
   localparam int unsigned REG_DST  = 2;
   localparam int unsigned REG_CNT  = 3;

   // control word bit positions
   localparam int unsigned CB_START = 0;
   localparam int unsigned CB_STOP  = 1;
   localparam int unsigned CB_CHAIN = 2;
   localparam int unsigned CB_FINAL = 3;

   typedef enum logic [2:0] {
      SQ_IDLE  = 3'd0,
      SQ_RD    = 3'd1,
      SQ_RWAIT = 3'd2,
      SQ_FEED  = 3'd3,
      SQ_COLL  = 3'd4,
      SQ_WR    = 3'd5,
      SQ_WWAIT = 3'd6,
      SQ_SEG   = 3'd7
   } seq_state_t;

endpackage

// File: rtl/cdma_stage_regs.sv
module cdma_stage_regs
   import cdma_pkg::*;
#(
   parameter int unsigned ADDR_W     = 32,
   parameter int unsigned CNT_W      = 32,
   parameter int unsigned REG_AW     = 2,
   parameter int unsigned REG_DW     = 32,
   parameter int unsigned ALIGN_LSBS = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic [REG_AW-1:0] wr_addr,
   input  logic [REG_DW-1:0] wr_data,
   output logic [ADDR_W-1:0] stg_src,
   output logic [ADDR_W-1:0] stg_dst,
   output logic [CNT_W-1:0]  stg_cnt,
   output logic              cmd_start,
   output logic              cmd_stop,
   output logic              cmd_chain,
   output logic              cmd_final
);

   localparam logic [REG_AW-1:0] A_CTRL = REG_AW'(REG_CTRL);
   localparam logic [REG_AW-1:0] A_SRC  = REG_AW'(REG_SRC);
   localparam logic [REG_AW-1:0] A_DST  = REG_AW'(REG_DST);
   localparam logic [REG_AW-1:0] A_CNT  = REG_AW'(REG_CNT);

   logic [ADDR_W-1:0] wr_ptr;

   // pointer alignment variant
   generate
      if (ALIGN_LSBS > 0) begin : g_align
         assign wr_ptr = {wr_data[ADDR_W-1:ALIGN_LSBS], {ALIGN_LSBS{1'b0}}};
      end else begin : g_noalign
         assign wr_ptr = wr_data[ADDR_W-1:0];
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         stg_src <= '0;
         stg_dst <= '0;
         stg_cnt <= '0;
      end else if (wr_en) begin
         if (wr_addr == A_SRC) stg_src <= wr_ptr;
         if (wr_addr == A_DST) stg_dst <= wr_ptr;
         if (wr_addr == A_CNT) stg_cnt <= wr_data[CNT_W-1:0];
      end
   end

   // control bits are commands: they act in the write cycle and hold nothing
   logic ctrl_hit;
   assign ctrl_hit  = wr_en && (wr_addr == A_CTRL);
   assign cmd_start = ctrl_hit && wr_data[CB_START];
   assign cmd_stop  = ctrl_hit && wr_data[CB_STOP];
   assign cmd_chain = ctrl_hit && wr_data[CB_CHAIN];
   assign cmd_final = ctrl_hit && wr_data[CB_FINAL];

endmodule

// File: rtl/cdma_active_ptrs.sv
module cdma_active_ptrs #(
   parameter int unsigned ADDR_W    = 32,
   parameter int unsigned CNT_W     = 32,
   parameter int unsigned BLK_BYTES = 16
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              load,
   input  logic [ADDR_W-1:0] ld_src,
   input  logic [ADDR_W-1:0] ld_dst,
   input  logic [CNT_W-1:0]  ld_cnt,
   input  logic              adv_src,
   input  logic              adv_dst,
   input  logic              consume,
   output logic [ADDR_W-1:0] act_src,
   output logic [ADDR_W-1:0] act_dst,
   output logic              rem_last,
   output logic              rem_zero
);

   localparam logic [ADDR_W-1:0] STEP_A = ADDR_W'(BLK_BYTES);
   localparam logic [CNT_W-1:0]  STEP_C = CNT_W'(BLK_BYTES);

   logic [CNT_W-1:0] act_rem;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         act_src <= '0;
         act_dst <= '0;
         act_rem <= '0;
      end else if (load) begin
         act_src <= ld_src;
         act_dst <= ld_dst;
         act_rem <= ld_cnt;
      end else begin
         if (adv_src) act_src <= act_src + STEP_A;
         if (adv_dst) act_dst <= act_dst + STEP_A;
         if (consume) act_rem <= rem_last ? '0 : act_rem - STEP_C;
      end
   end

   assign rem_last = (act_rem <= STEP_C);
   assign rem_zero = (act_rem == '0);

   // R4
   rem_down_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !load |=> (act_rem <= $past(act_rem)));

   // R4
   rem_sat_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (consume && !load && rem_last) |=> rem_zero);

endmodule

// File: rtl/cdma_seq_fsm.sv
module cdma_seq_fsm
   import cdma_pkg::*;
#(
   parameter int unsigned ADDR_W    = 32,
   parameter int unsigned BLK_BYTES = 16,
   localparam int unsigned BLK_W    = BLK_BYTES * 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cmd_start,
   input  logic              cmd_stop,
   input  logic              cmd_chain,
   input  logic              cmd_final,
   input  logic              cnt_is_zero,
   input  logic [ADDR_W-1:0] act_src,
   input  logic [ADDR_W-1:0] act_dst,
   input  logic              rem_last,
   input  logic              rem_zero,
   output logic              load,
   output logic              adv_src,
   output logic              adv_dst,
   output logic              consume,
   output logic              mem_req_valid,
   input  logic              mem_req_ready,
   output logic              mem_req_write,
   output logic [ADDR_W-1:0] mem_req_addr,
   output logic [BLK_W-1:0]  mem_req_data,
   input  logic              mem_rsp_valid,
   input  logic [BLK_W-1:0]  mem_rsp_data,
   input  logic              mem_rsp_err,
   output logic              core_in_valid,
   input  logic              core_in_ready,
   output logic [BLK_W-1:0]  core_in_data,
   input  logic              core_out_valid,
   output logic              core_out_ready,
   input  logic [BLK_W-1:0]  core_out_data,
   output logic              core_job_start,
   output logic              core_abort,
   output logic              busy,
   output logic              seg_fed,
   output logic              cnt_err,
   output logic              bus_err
);

   seq_state_t       state;
   logic [BLK_W-1:0] blk_q;
   logic             final_q;
   logic             waiting;
   logic             stop_hit;
   logic             err_hit;
   logic             rsp_ok;

   assign waiting  = (state == SQ_RWAIT) || (state == SQ_WWAIT);
   assign stop_hit = cmd_stop && (state != SQ_IDLE);
   assign err_hit  = waiting && mem_rsp_valid && mem_rsp_err;
   assign rsp_ok   = mem_rsp_valid && !mem_rsp_err;

   assign load = cmd_start && !cnt_is_zero &&
                 ((state == SQ_IDLE) || ((state == SQ_SEG) && !cmd_stop));
   assign core_job_start = load && (state == SQ_IDLE);
   assign core_abort     = stop_hit || err_hit;

   assign adv_src = (state == SQ_RWAIT) && rsp_ok && !cmd_stop;
   assign adv_dst = (state == SQ_WWAIT) && rsp_ok && !cmd_stop;
   assign consume = (state == SQ_FEED) && core_in_ready && !cmd_stop;
   assign seg_fed = consume && rem_last;

   assign mem_req_valid  = (state == SQ_RD) || (state == SQ_WR);
   assign mem_req_write  = (state == SQ_WR);
   assign mem_req_addr   = (state == SQ_WR) ? act_dst : act_src;
   assign mem_req_data   = blk_q;
   assign core_in_valid  = (state == SQ_FEED);
   assign core_in_data   = blk_q;
   assign core_out_ready = (state == SQ_COLL);
   assign busy           = (state != SQ_IDLE);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state   <= SQ_IDLE;
         blk_q   <= '0;
         final_q <= 1'b0;
         cnt_err <= 1'b0;
         bus_err <= 1'b0;
      end else begin
         if (err_hit) bus_err <= 1'b1;
         if (stop_hit) begin
            state <= SQ_IDLE;
         end else begin
            unique case (state)
               SQ_IDLE: if (cmd_start) begin
                  if (cnt_is_zero) begin
                     cnt_err <= 1'b1;
                  end else begin
                     cnt_err <= 1'b0;
                     bus_err <= 1'b0;
                     final_q <= cmd_final || !cmd_chain;
                     state   <= SQ_RD;
                  end
               end
               SQ_SEG: if (cmd_start) begin
                  if (cnt_is_zero) begin
                     cnt_err <= 1'b1;
                  end else begin
                     cnt_err <= 1'b0;
                     final_q <= cmd_final;
                     state   <= SQ_RD;
                  end
               end
               SQ_RD:    if (mem_req_ready) state <= SQ_RWAIT;
               SQ_RWAIT: if (mem_rsp_valid) begin
                  if (mem_rsp_err) begin
                     state <= SQ_IDLE;
                  end else begin
                     blk_q <= mem_rsp_data;
                     state <= SQ_FEED;
                  end
               end
               SQ_FEED:  if (core_in_ready) state <= SQ_COLL;
               SQ_COLL:  if (core_out_valid) begin
                  blk_q <= core_out_data;
                  state <= SQ_WR;
               end
               SQ_WR:    if (mem_req_ready) state <= SQ_WWAIT;
               SQ_WWAIT: if (mem_rsp_valid) begin
                  if (mem_rsp_err)  state <= SQ_IDLE;
                  else if (!rem_zero) state <= SQ_RD;
                  else if (final_q) state <= SQ_IDLE;
                  else              state <= SQ_SEG;
               end
               default: state <= SQ_IDLE;
            endcase
         end
      end
   end

   // R1
   idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (state == SQ_IDLE) |-> (!mem_req_valid && !core_in_valid));

   // R3
   cnt_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ((state == SQ_IDLE) && cmd_start && cnt_is_zero) |=> (!busy && cnt_err));

   // R12
   busy_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ((state == SQ_IDLE) && load) |=> busy);

   // R10
   bus_stop_chk: assert property (@(posedge clk) disable iff (!rst_n)
      err_hit |=> (!busy && bus_err));

   // R11
   stop_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
      stop_hit |=> !busy);

   // R5
   wr_after_rd_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_req_valid && mem_req_write) |-> !core_in_valid);

endmodule

// File: rtl/cdma_shadow_seq.sv
module cdma_shadow_seq
   import cdma_pkg::*;
#(
   parameter int unsigned ADDR_W     = 32,
   parameter int unsigned CNT_W      = 32,
   parameter int unsigned BLK_BYTES  = 16,
   parameter int unsigned REG_AW     = 2,
   parameter int unsigned REG_DW     = 32,
   parameter int unsigned ALIGN_LSBS = 2
) (
   input  logic                   clk,
   input  logic                   rst_n,
   input  logic                   reg_wr_en,
   input  logic [REG_AW-1:0]      reg_addr,
   input  logic [REG_DW-1:0]      reg_wdata,
   output logic                   mem_req_valid,
   input  logic                   mem_req_ready,
   output logic                   mem_req_write,
   output logic [ADDR_W-1:0]      mem_req_addr,
   output logic [BLK_BYTES*8-1:0] mem_req_data,
   input  logic                   mem_rsp_valid,
   input  logic [BLK_BYTES*8-1:0] mem_rsp_data,
   input  logic                   mem_rsp_err,
   output logic                   core_in_valid,
   input  logic                   core_in_ready,
   output logic [BLK_BYTES*8-1:0] core_in_data,
   input  logic                   core_out_valid,
   output logic                   core_out_ready,
   input  logic [BLK_BYTES*8-1:0] core_out_data,
   output logic                   core_job_start,
   output logic                   core_abort,
   output logic                   busy,
   output logic                   seg_fed,
   output logic                   cnt_err,
   output logic                   bus_err
);

   // elaboration-time parameter checks
   generate
      if (ADDR_W > REG_DW || CNT_W > REG_DW)
         $error("pointer or count wider than the register word");
      if (BLK_BYTES < 4 || (BLK_BYTES & (BLK_BYTES - 1)) != 0)
         $error("block size must be a power of two, at least 4");
      if (REG_AW < 2)
         $error("register offset needs at least 2 bits");
      if (ALIGN_LSBS >= ADDR_W || (1 << ALIGN_LSBS) > BLK_BYTES)
         $error("alignment exceeds the block size");
   endgenerate

   logic [ADDR_W-1:0] stg_src, stg_dst, act_src, act_dst;
   logic [CNT_W-1:0]  stg_cnt;
   logic cmd_start, cmd_stop, cmd_chain, cmd_final;
   logic load, adv_src, adv_dst, consume, rem_last, rem_zero;

   cdma_stage_regs #(
      .ADDR_W(ADDR_W), .CNT_W(CNT_W), .REG_AW(REG_AW),
      .REG_DW(REG_DW), .ALIGN_LSBS(ALIGN_LSBS)
   ) stage_i (
      .clk(clk), .rst_n(rst_n),
      .wr_en(reg_wr_en), .wr_addr(reg_addr), .wr_data(reg_wdata),
      .stg_src(stg_src), .stg_dst(stg_dst), .stg_cnt(stg_cnt),
      .cmd_start(cmd_start), .cmd_stop(cmd_stop),
      .cmd_chain(cmd_chain), .cmd_final(cmd_final)
   );

   cdma_active_ptrs #(
      .ADDR_W(ADDR_W), .CNT_W(CNT_W), .BLK_BYTES(BLK_BYTES)
   ) active_i (
      .clk(clk), .rst_n(rst_n),
      .load(load), .ld_src(stg_src), .ld_dst(stg_dst), .ld_cnt(stg_cnt),
      .adv_src(adv_src), .adv_dst(adv_dst), .consume(consume),
      .act_src(act_src), .act_dst(act_dst),
      .rem_last(rem_last), .rem_zero(rem_zero)
   );

   cdma_seq_fsm #(
      .ADDR_W(ADDR_W), .BLK_BYTES(BLK_BYTES)
   ) fsm_i (
      .clk(clk), .rst_n(rst_n),
      .cmd_start(cmd_start), .cmd_stop(cmd_stop),
      .cmd_chain(cmd_chain), .cmd_final(cmd_final),
      .cnt_is_zero(stg_cnt == '0),
      .act_src(act_src), .act_dst(act_dst),
      .rem_last(rem_last), .rem_zero(rem_zero),
      .load(load), .adv_src(adv_src), .adv_dst(adv_dst), .consume(consume),
      .mem_req_valid(mem_req_valid), .mem_req_ready(mem_req_ready),
      .mem_req_write(mem_req_write), .mem_req_addr(mem_req_addr),
      .mem_req_data(mem_req_data), .mem_rsp_valid(mem_rsp_valid),
      .mem_rsp_data(mem_rsp_data), .mem_rsp_err(mem_rsp_err),
      .core_in_valid(core_in_valid), .core_in_ready(core_in_ready),
      .core_in_data(core_in_data), .core_out_valid(core_out_valid),
      .core_out_ready(core_out_ready), .core_out_data(core_out_data),
      .core_job_start(core_job_start), .core_abort(core_abort),
      .busy(busy), .seg_fed(seg_fed), .cnt_err(cnt_err), .bus_err(bus_err)
   );

   // R2
   req_align_chk: assert property (@(posedge clk) disable iff (!rst_n)
      mem_req_valid |-> (mem_req_addr[1:0] == 2'b00));

endmodule

// File: tb/cdma_shadow_seq_tb.sv
module cdma_shadow_seq_tb_top;

   localparam int unsigned AW  = 16;
   localparam int unsigned BB  = 16;
   localparam int unsigned BW  = BB * 8;
   localparam logic [BW-1:0] CKEY = 128'h0F1E2D3C_4B5A6978_8796A5B4_C3D2E1F0;
   localparam int NV = 5;
   localparam logic [15:0] V_SRC [NV] = '{16'h0100, 16'h0200, 16'h0000, 16'h0140, 16'h0080};
   localparam logic [15:0] V_DST [NV] = '{16'h0300, 16'h0200, 16'h0380, 16'h0240, 16'h0280};
   localparam logic [31:0] V_CNT [NV] = '{32'd64, 32'd40, 32'd16, 32'd17, 32'd1};

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   always #5 clk = ~clk;

   logic          reg_wr_en = 1'b0;
   logic [1:0]    reg_addr = '0;
   logic [31:0]   reg_wdata = '0;
   logic          mem_req_valid, mem_req_write, mem_rsp_valid, mem_rsp_err;
   logic [AW-1:0] mem_req_addr;
   logic [BW-1:0] mem_req_data, mem_rsp_data, core_in_data, core_out_data;
   logic          core_in_valid, core_in_ready, core_out_valid, core_out_ready;
   logic          core_job_start, core_abort, busy, seg_fed, cnt_err, bus_err;

   cdma_shadow_seq #(.ADDR_W(AW), .CNT_W(32), .BLK_BYTES(BB)) dut_i (
      .clk(clk), .rst_n(rst_n),
      .reg_wr_en(reg_wr_en), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
      .mem_req_valid(mem_req_valid), .mem_req_ready(1'b1),
      .mem_req_write(mem_req_write), .mem_req_addr(mem_req_addr),
      .mem_req_data(mem_req_data), .mem_rsp_valid(mem_rsp_valid),
      .mem_rsp_data(mem_rsp_data), .mem_rsp_err(mem_rsp_err),
      .core_in_valid(core_in_valid), .core_in_ready(core_in_ready),
      .core_in_data(core_in_data), .core_out_valid(core_out_valid),
      .core_out_ready(core_out_ready), .core_out_data(core_out_data),
      .core_job_start(core_job_start), .core_abort(core_abort),
      .busy(busy), .seg_fed(seg_fed), .cnt_err(cnt_err), .bus_err(bus_err)
   );

   // memory model: 64 blocks, one-cycle response, optional error address
   logic [BW-1:0] mem [64];
   logic [BW-1:0] snap [64];
   logic          err_en = 1'b0;
   logic [AW-1:0] err_addr = '0;

   function automatic logic [BW-1:0] pat(input int i);
      return {4{8'(i), 8'hC3, 8'(i * 7), 8'h5A}};
   endfunction

   always @(posedge clk) begin
      if (!rst_n) begin
         for (int i = 0; i < 64; i++) mem[i] <= pat(i);
         mem_rsp_valid <= 1'b0;
         mem_rsp_err   <= 1'b0;
         mem_rsp_data  <= '0;
      end else begin
         mem_rsp_valid <= mem_req_valid;
         mem_rsp_err   <= mem_req_valid && err_en && (mem_req_addr == err_addr);
         mem_rsp_data  <= mem[mem_req_addr[9:4]];
         if (mem_req_valid && mem_req_write) mem[mem_req_addr[9:4]] <= mem_req_data;
      end
   end

   // core model: one block in flight, result = input ^ CKEY
   logic          c_full;
   logic [BW-1:0] c_hold;
   assign core_in_ready  = !c_full;
   assign core_out_valid = c_full;
   assign core_out_data  = c_hold;
   always @(posedge clk) begin
      if (!rst_n) begin
         c_full <= 1'b0;
         c_hold <= '0;
      end else if (core_in_valid && core_in_ready) begin
         c_full <= 1'b1;
         c_hold <= core_in_data ^ CKEY;
      end else if (core_out_valid && core_out_ready) begin
         c_full <= 1'b0;
      end
   end

   // event counters, never cleared; tests use deltas
   int rd_tot = 0, wr_tot = 0, fed_tot = 0, js_tot = 0, ab_tot = 0;
   logic [AW-1:0] rd_log [256];
   always @(posedge clk) begin
      if (rst_n) begin
         if (mem_req_valid && !mem_req_write) begin
            rd_log[rd_tot[7:0]] <= mem_req_addr;
            rd_tot <= rd_tot + 1;
         end
         if (mem_req_valid && mem_req_write) wr_tot <= wr_tot + 1;
         if (seg_fed) fed_tot <= fed_tot + 1;
         if (core_job_start) js_tot <= js_tot + 1;
         if (core_abort) ab_tot <= ab_tot + 1;
      end
   end

   int nchk = 0, nfail = 0;

   task automatic chk(input bit ok, input string req, input logic [127:0] act,
                      input logic [127:0] exp);
      nchk++;
      if (!ok) begin
         nfail++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   task automatic wr(input logic [1:0] a, input logic [31:0] d);
      @(negedge clk);
      reg_wr_en = 1'b1; reg_addr = a; reg_wdata = d;
      @(negedge clk);
      reg_wr_en = 1'b0;
   endtask

   task automatic wait_idle();
      int n = 0;
      while (busy && n < 3000) begin
         @(negedge clk);
         n++;
      end
      if (busy) chk(1'b0, "watchdog idle", 128'd1, 128'd0);
   endtask

   task automatic setup(input logic [15:0] s, input logic [15:0] d, input logic [31:0] c);
      wr(2'd1, {16'h0, s});
      wr(2'd2, {16'h0, d});
      wr(2'd3, c);
   endtask

   task automatic check_blocks(input string req, input logic [15:0] s,
                               input logic [15:0] d, input int nb);
      for (int k = 0; k < nb; k++) begin
         logic [BW-1:0] e;
         e = snap[s[9:4] + k] ^ CKEY;
         chk(mem[d[9:4] + k] == e, req, mem[d[9:4] + k], e);
      end
   endtask

   // global watchdog
   initial begin
      repeat (150000) @(posedge clk);
      nfail++;
      $display("FAIL watchdog expired actual=1 expected=0");
      $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
      $finish;
   end

   initial begin
      int r0, w0, f0, j0, a0, nb;
      repeat (3) @(negedge clk);
      // R1 reset state
      chk(!busy && !cnt_err && !bus_err, "R1 reset flags", {busy, cnt_err, bus_err}, 0);
      chk(!mem_req_valid && !core_in_valid, "R1 reset idle ports",
          {mem_req_valid, core_in_valid}, 0);
      rst_n = 1'b1;
      @(negedge clk);

      // table-driven jobs: R4, R5, R7, R12
      for (int v = 0; v < NV; v++) begin
         nb = (V_CNT[v] + 15) / 16;
         snap = mem;
         r0 = rd_tot; w0 = wr_tot; f0 = fed_tot; j0 = js_tot;
         setup(V_SRC[v], V_DST[v], V_CNT[v]);
         wr(2'd0, 32'h1);
         chk(busy, "R12 busy after start", busy, 1);
         wait_idle();
         @(negedge clk);
         chk(rd_tot - r0 == nb, "R4 block reads", rd_tot - r0, nb);
         chk(wr_tot - w0 == nb, "R4 block writes", wr_tot - w0, nb);
         chk(rd_log[r0[7:0]] == V_SRC[v], "R4 first read addr", rd_log[r0[7:0]], V_SRC[v]);
         chk(fed_tot - f0 == 1, "R7 one fed pulse", fed_tot - f0, 1);
         chk(js_tot - j0 == 1, "R8 job start pulse", js_tot - j0, 1);
         check_blocks(V_SRC[v] == V_DST[v] ? "R5 in-place data" : "R4 result data",
                      V_SRC[v], V_DST[v], nb);
      end

      // R2 low pointer bits dropped
      snap = mem;
      r0 = rd_tot;
      setup(16'h0103, 16'h0307, 32'd16);
      wr(2'd0, 32'h1);
      wait_idle();
      chk(rd_log[r0[7:0]] == 16'h0100, "R2 aligned read addr", rd_log[r0[7:0]], 16'h0100);
      check_blocks("R2 aligned write", 16'h0100, 16'h0300, 1);

      // R3 zero count
      r0 = rd_tot;
      wr(2'd3, 32'd0);
      wr(2'd0, 32'h1);
      repeat (5) @(negedge clk);
      chk(cnt_err && !busy, "R3 zero count flag", {cnt_err, busy}, 2'b10);
      chk(rd_tot == r0, "R3 no transfer", rd_tot - r0, 0);

      // R6 staged writes while busy; also clears R3 flag
      snap = mem;
      r0 = rd_tot;
      setup(16'h0000, 16'h0200, 32'd48);
      wr(2'd0, 32'h1);
      chk(!cnt_err, "R3 cleared by start", cnt_err, 0);
      setup(16'h0100, 16'h0300, 32'd16);
      wait_idle();
      chk(rd_tot - r0 == 3, "R6 running count kept", rd_tot - r0, 3);
      chk(rd_log[r0[7:0]] == 16'h0000, "R6 running src kept", rd_log[r0[7:0]], 0);
      check_blocks("R6 running dst kept", 16'h0000, 16'h0200, 3);
      r0 = rd_tot;
      wr(2'd0, 32'h1);
      wait_idle();
      chk(rd_tot - r0 == 1, "R6 next job count", rd_tot - r0, 1);
      chk(rd_log[r0[7:0]] == 16'h0100, "R6 next job src", rd_log[r0[7:0]], 16'h0100);

      // R8 / R9 chained segments
      j0 = js_tot; f0 = fed_tot; w0 = wr_tot;
      setup(16'h0000, 16'h0200, 32'd32);
      wr(2'd0, 32'h5);
      while (wr_tot - w0 < 2) @(negedge clk);
      repeat (6) @(negedge clk);
      chk(busy, "R8 waits after segment", busy, 1);
      setup(16'h0040, 16'h0240, 32'd16);
      wr(2'd0, 32'h5);
      while (wr_tot - w0 < 3) @(negedge clk);
      repeat (6) @(negedge clk);
      chk(busy, "R9 final bit not sticky", busy, 1);
      setup(16'h0080, 16'h0280, 32'd16);
      wr(2'd0, 32'hD);
      wait_idle();
      chk(js_tot - j0 == 1, "R8 no restart on segment", js_tot - j0, 1);
      chk(fed_tot - f0 == 3, "R7 fed per segment", fed_tot - f0, 3);
      chk(wr_tot - w0 == 4, "R8 segment blocks", wr_tot - w0, 4);

      // R10 bus error on second read
      err_en = 1'b1; err_addr = 16'h0110;
      r0 = rd_tot; w0 = wr_tot; a0 = ab_tot;
      setup(16'h0100, 16'h0300, 32'd48);
      wr(2'd0, 32'h1);
      wait_idle();
      err_en = 1'b0;
      repeat (8) @(negedge clk);
      chk(bus_err && !busy, "R10 stop and flag", {bus_err, busy}, 2'b10);
      chk(rd_tot - r0 == 2 && wr_tot - w0 == 1, "R10 halted transfers",
          {rd_tot - r0, wr_tot - w0}, {32'd2, 32'd1});
      chk(ab_tot - a0 == 1, "R10 core abort", ab_tot - a0, 1);
      setup(16'h0000, 16'h0200, 32'd16);
      wr(2'd0, 32'h1);
      wait_idle();
      chk(!bus_err, "R10 cleared by start", bus_err, 0);

      // R11 stop mid-job
      w0 = wr_tot; a0 = ab_tot;
      setup(16'h0000, 16'h0200, 32'd64);
      wr(2'd0, 32'h1);
      while (wr_tot - w0 < 1) @(negedge clk);
      wr(2'd0, 32'h2);
      chk(!busy, "R11 busy drops", busy, 0);
      chk(ab_tot - a0 == 1, "R11 core abort", ab_tot - a0, 1);
      @(negedge clk);
      r0 = rd_tot; w0 = wr_tot;
      repeat (10) @(negedge clk);
      chk(rd_tot == r0 && wr_tot == w0, "R11 no further requests",
          {rd_tot - r0, wr_tot - w0}, 0);

      $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
      $finish;
   end

endmodule